// File: doc/BRIEF.md
# Far Control Transfer Privilege Checker

This block rules on one far control transfer per request. The request gives the operation, the nested-task flag, the current privilege level (CPL), the requested privilege level (RPL) of the selector, and the kind, DPL and table of the descriptor being referenced. When that descriptor is a gate, the request also gives the kind and DPL of the gate's destination descriptor. The block first checks that the operation may use that descriptor kind from that table. It then applies the privilege comparison that fits the path. The result is one of four classes, a new CPL and a flag that says whether the old stack pointer must also be popped. An illegal transfer gives a general-protection fault with vector 13 instead.

The block is purely a decision unit. A sequencer in the front end presents a request with a one-cycle `req_valid` pulse and reads the registered response on the next cycle. Stack switching and the task-switch sequence belong to other blocks, and they act on the class returned here.

Top module: `xfer_priv_check`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the next cycle, carrying that request's response. A cycle without a request gives `rsp_valid` low on the next cycle.
- R2: The encodings are as follows. For `req_op`: 0 JMP, 1 CALL, 2 RET, 3 IRET, 4 software interrupt, 5 exception, 6 external interrupt, 7 reserved (always faults). For the kinds: 0 non-conforming code, 1 conforming code, 2 call gate, 3 trap gate, 4 interrupt gate, 5 task gate, 6 task state segment (TSS), 7 data. For `req_table`: 0 global, 1 local, 2 interrupt, 3 reserved (always faults). For `rsp_result`: 0 same level, 1 through gate, 2 return to lower privilege, 3 task switch. A privilege level of 0 is the most privileged.
- R3: An operation that uses a descriptor kind or a table not permitted for it raises a fault. Code segments are legal only for JMP, CALL, RET and IRET with the nested-task flag clear, and only from the global or local table. Call gates are legal only for CALL. Trap and interrupt gates are legal only for the three interrupt operations, and only from the interrupt table. Data descriptors are never legal.
- R4: JMP or CALL straight to a code segment needs RPL ≤ CPL. A non-conforming segment also needs DPL = CPL, and a conforming segment needs DPL ≤ CPL. The result is 0 and the new CPL equals the old one.
- R5: RET, or IRET with the flag clear, to a code segment needs DPL ≥ CPL and RPL ≥ CPL, and the new CPL is the RPL. If RPL equals CPL the result is 0 and there is no pop. Otherwise the result is 2 and the pop flag is set.
- R6: JMP or CALL to a TSS is legal only from the global table with DPL ≥ CPL. The result is 3.
- R7: A call gate, trap gate or interrupt gate needs gate DPL ≥ CPL, a destination of kind 0 or 1, and a destination DPL ≤ CPL. The result is 1 and the new CPL is the destination DPL.
- R8: A task gate is legal for JMP or CALL from the global or local table, or for an interrupt operation from the interrupt table. It needs gate DPL ≥ CPL and a destination of kind 6. The result is 3. Every task-switch result reports the requester's CPL unchanged.
- R9: IRET with the nested-task flag set is legal only with a TSS from the global table, and then gives result 3 with no privilege comparison.
- R10: A fault response has `rsp_fault` high, vector 13, result 0, the requester's CPL and no pop. A legal response has vector 0.
- R11: While reset is high, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 3 | Operation code |
| req_nt | input | 1 | Nested-task flag |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Selector requested privilege level |
| req_kind | input | 3 | Referenced descriptor kind |
| req_dpl | input | 2 | Referenced descriptor DPL |
| req_table | input | 2 | Table the descriptor came from |
| req_dst_kind | input | 3 | Gate destination descriptor kind |
| req_dst_dpl | input | 2 | Gate destination descriptor DPL |
| rsp_valid | output | 1 | Response strobe |
| rsp_result | output | 2 | Transfer class |
| rsp_fault | output | 1 | General-protection fault |
| rsp_vector | output | 8 | Fault vector, 0 when legal |
| rsp_cpl | output | 2 | Privilege level after the transfer |
| rsp_pop_sp | output | 1 | Old stack pointer must be popped |

## Verification
The block has only one register stage, so any wrong decision shows up in full at the ports one cycle after the request that caused it. A misrouted path or a wrong comparison gives a fault where a legal class is expected, or the reverse. A wrong new-CPL choice shows up as a wrong `rsp_cpl` on that same response. The bench sweeps every operation, table and privilege triple against every descriptor kind, and it sweeps gate destinations too, so a defect in a single cell of the matrix cannot stay hidden.

// File: rtl/xfer_priv_pkg.sv
package xfer_priv_pkg;

  localparam int OP_W   = 3;
  localparam int KIND_W = 3;
  localparam int TBL_W  = 2;
  localparam int RES_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_JMP    = 3'd0,
    OP_CALL   = 3'd1,
    OP_RET    = 3'd2,
    OP_IRET   = 3'd3,
    OP_SWINT  = 3'd4,
    OP_EXC    = 3'd5,
    OP_EXTINT = 3'd6,
    OP_RSVD   = 3'd7
  } xop_e;

  typedef enum logic [KIND_W-1:0] {
    DK_CODE_NC   = 3'd0,
    DK_CODE_CONF = 3'd1,
    DK_CALL_GATE = 3'd2,
    DK_TRAP_GATE = 3'd3,
    DK_INT_GATE  = 3'd4,
    DK_TASK_GATE = 3'd5,
    DK_TSS       = 3'd6,
    DK_DATA      = 3'd7
  } dkind_e;

  typedef enum logic [TBL_W-1:0] {
    TB_GLOBAL = 2'd0,
    TB_LOCAL  = 2'd1,
    TB_INTR   = 2'd2,
    TB_RSVD   = 2'd3
  } dtab_e;

  typedef enum logic [RES_W-1:0] {
    RES_SAME  = 2'd0,
    RES_GATE  = 2'd1,
    RES_LOWER = 2'd2,
    RES_TASK  = 2'd3
  } xres_e;

  typedef enum logic [2:0] {
    PATH_NONE      = 3'd0,
    PATH_DIRECT    = 3'd1,
    PATH_RETURN    = 3'd2,
    PATH_TSS       = 3'd3,
    PATH_GATE_CODE = 3'd4,
    PATH_GATE_TASK = 3'd5,
    PATH_NESTED    = 3'd6
  } path_e;

  function automatic logic is_code_kind(input dkind_e k);
    return (k == DK_CODE_NC) || (k == DK_CODE_CONF);
  endfunction

  function automatic logic is_intr_op(input xop_e o);
    return (o == OP_SWINT) || (o == OP_EXC) || (o == OP_EXTINT);
  endfunction

endpackage

// File: rtl/xfer_type_matrix.sv
module xfer_type_matrix
  import xfer_priv_pkg::*;
(
  input  xop_e   op,
  input  logic   nt,
  input  dkind_e kind,
  input  dtab_e  table_sel,
  output path_e  path
);

  logic w_far_jc;
  logic w_ret_plain;
  logic w_ret_nested;
  logic w_intr;
  logic w_seg_tab;
  logic w_glb_tab;
  logic w_idt_tab;

  assign w_far_jc     = (op == OP_JMP) || (op == OP_CALL);
  assign w_ret_plain  = (op == OP_RET) || ((op == OP_IRET) && !nt);
  assign w_ret_nested = (op == OP_IRET) && nt;
  assign w_intr       = is_intr_op(op);
  assign w_seg_tab    = (table_sel == TB_GLOBAL) || (table_sel == TB_LOCAL);
  assign w_glb_tab    = (table_sel == TB_GLOBAL);
  assign w_idt_tab    = (table_sel == TB_INTR);

  always_comb begin
    path = PATH_NONE;
    unique case (kind)
      DK_CODE_NC, DK_CODE_CONF: begin
        if (w_seg_tab && w_far_jc)         path = PATH_DIRECT;
        else if (w_seg_tab && w_ret_plain) path = PATH_RETURN;
      end
      DK_CALL_GATE: begin
        if (w_seg_tab && (op == OP_CALL)) path = PATH_GATE_CODE;
      end
      DK_TRAP_GATE, DK_INT_GATE: begin
        if (w_idt_tab && w_intr) path = PATH_GATE_CODE;
      end
      DK_TASK_GATE: begin
        if ((w_seg_tab && w_far_jc) || (w_idt_tab && w_intr)) path = PATH_GATE_TASK;
      end
      DK_TSS: begin
        if (w_glb_tab && w_far_jc)          path = PATH_TSS;
        else if (w_glb_tab && w_ret_nested) path = PATH_NESTED;
      end
      default: path = PATH_NONE;
    endcase
  end

endmodule

// File: rtl/xfer_priv_compare.sv
module xfer_priv_compare
  import xfer_priv_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  path_e            path,
  input  dkind_e           kind,
  input  logic [PL_W-1:0]  cpl,
  input  logic [PL_W-1:0]  rpl,
  input  logic [PL_W-1:0]  dpl,
  input  dkind_e           dst_kind,
  input  logic [PL_W-1:0]  dst_dpl,
  output logic             ok,
  output xres_e            result,
  output logic [PL_W-1:0]  new_cpl,
  output logic             pop_sp
);

  // a is at least as privileged as b
  function automatic logic as_priv(input logic [PL_W-1:0] a, input logic [PL_W-1:0] b);
    return a <= b;
  endfunction

  // a is no more privileged than b
  function automatic logic no_more_priv(input logic [PL_W-1:0] a, input logic [PL_W-1:0] b);
    return a >= b;
  endfunction

  logic w_direct_ok;
  logic w_return_ok;
  logic w_gate_dpl_ok;
  logic w_gate_code_ok;
  logic w_gate_task_ok;
  logic w_lvl_change;

  assign w_direct_ok    = as_priv(rpl, cpl) &&
                          ((kind == DK_CODE_CONF) ? as_priv(dpl, cpl) : (dpl == cpl));
  assign w_return_ok    = no_more_priv(dpl, cpl) && no_more_priv(rpl, cpl);
  assign w_gate_dpl_ok  = no_more_priv(dpl, cpl);
  assign w_gate_code_ok = w_gate_dpl_ok && is_code_kind(dst_kind) && as_priv(dst_dpl, cpl);
  assign w_gate_task_ok = w_gate_dpl_ok && (dst_kind == DK_TSS);
  assign w_lvl_change   = (rpl != cpl);

  always_comb begin
    ok      = 1'b0;
    result  = RES_SAME;
    new_cpl = cpl;
    pop_sp  = 1'b0;
    unique case (path)
      PATH_DIRECT: begin
        ok = w_direct_ok;
      end
      PATH_RETURN: begin
        ok      = w_return_ok;
        result  = w_lvl_change ? RES_LOWER : RES_SAME;
        new_cpl = rpl;
        pop_sp  = w_lvl_change;
      end
      PATH_TSS: begin
        ok     = w_gate_dpl_ok;
        result = RES_TASK;
      end
      PATH_GATE_CODE: begin
        ok      = w_gate_code_ok;
        result  = RES_GATE;
        new_cpl = dst_dpl;
      end
      PATH_GATE_TASK: begin
        ok     = w_gate_task_ok;
        result = RES_TASK;
      end
      PATH_NESTED: begin
        ok     = 1'b1;
        result = RES_TASK;
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/xfer_resp_reg.sv
module xfer_resp_reg
  import xfer_priv_pkg::*;
#(
  parameter int PL_W      = 2,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_ok,
  input  xres_e            in_result,
  input  logic [PL_W-1:0]  in_new_cpl,
  input  logic             in_pop,
  input  logic [PL_W-1:0]  in_cur_cpl,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_result,
  output logic             rsp_fault,
  output logic [VEC_W-1:0] rsp_vector,
  output logic [PL_W-1:0]  rsp_cpl,
  output logic             rsp_pop_sp
);

  localparam logic [VEC_W-1:0] GP_VEC = VEC_W'(FAULT_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
      rsp_fault  <= 1'b0;
      rsp_vector <= '0;
      rsp_cpl    <= '0;
      rsp_pop_sp <= 1'b0;
    end else begin
      rsp_valid <= in_valid;
      if (in_valid) begin
        rsp_fault  <= !in_ok;
        rsp_result <= in_ok ? in_result : RES_SAME;
        rsp_vector <= in_ok ? '0 : GP_VEC;
        rsp_cpl    <= in_ok ? in_new_cpl : in_cur_cpl;
        rsp_pop_sp <= in_ok && in_pop;
      end
    end
  end

  assert_fault_shape_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_vector == GP_VEC && rsp_result == RES_SAME && !rsp_pop_sp));

  assert_legal_no_vector_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_vector == '0));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);

endmodule

// File: rtl/xfer_priv_check.sv
module xfer_priv_check
  import xfer_priv_pkg::*;
#(
  parameter int PL_W      = 2,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic              req_nt,
  input  logic [PL_W-1:0]   req_cpl,
  input  logic [PL_W-1:0]   req_rpl,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [PL_W-1:0]   req_dpl,
  input  logic [TBL_W-1:0]  req_table,
  input  logic [KIND_W-1:0] req_dst_kind,
  input  logic [PL_W-1:0]   req_dst_dpl,
  output logic              rsp_valid,
  output logic [RES_W-1:0]  rsp_result,
  output logic              rsp_fault,
  output logic [VEC_W-1:0]  rsp_vector,
  output logic [PL_W-1:0]   rsp_cpl,
  output logic              rsp_pop_sp
);

  xop_e            w_op;
  dkind_e          w_kind;
  dkind_e          w_dst_kind;
  dtab_e           w_table;
  path_e           w_path;
  logic            w_ok;
  xres_e           w_result;
  logic [PL_W-1:0] w_new_cpl;
  logic            w_pop;

  assign w_op       = xop_e'(req_op);
  assign w_kind     = dkind_e'(req_kind);
  assign w_dst_kind = dkind_e'(req_dst_kind);
  assign w_table    = dtab_e'(req_table);

  xfer_type_matrix u_matrix (
    .op        (w_op),
    .nt        (req_nt),
    .kind      (w_kind),
    .table_sel (w_table),
    .path      (w_path)
  );

  xfer_priv_compare #(.PL_W(PL_W)) u_compare (
    .path     (w_path),
    .kind     (w_kind),
    .cpl      (req_cpl),
    .rpl      (req_rpl),
    .dpl      (req_dpl),
    .dst_kind (w_dst_kind),
    .dst_dpl  (req_dst_dpl),
    .ok       (w_ok),
    .result   (w_result),
    .new_cpl  (w_new_cpl),
    .pop_sp   (w_pop)
  );

  xfer_resp_reg #(.PL_W(PL_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (req_valid),
    .in_ok      (w_ok),
    .in_result  (w_result),
    .in_new_cpl (w_new_cpl),
    .in_pop     (w_pop),
    .in_cur_cpl (req_cpl),
    .rsp_valid  (rsp_valid),
    .rsp_result (rsp_result),
    .rsp_fault  (rsp_fault),
    .rsp_vector (rsp_vector),
    .rsp_cpl    (rsp_cpl),
    .rsp_pop_sp (rsp_pop_sp)
  );

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_no_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_illegal_path_faults_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && w_path == PATH_NONE) |=> rsp_fault);

  assert_pop_only_lower_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_pop_sp) |-> (!rsp_fault && rsp_result == RES_LOWER));

  assert_lower_drops_priv_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_result == RES_LOWER) |-> (rsp_cpl > $past(req_cpl)));

  assert_tss_from_global_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && $past(req_kind) == DK_TSS) |-> ($past(req_table) == TB_GLOBAL));

  assert_gate_not_lower_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_result == RES_GATE) |-> (rsp_cpl <= $past(req_cpl)));

  assert_task_keeps_cpl_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault && rsp_result == RES_TASK) |-> (rsp_cpl == $past(req_cpl)));

  assert_fault_keeps_cpl_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_cpl == $past(req_cpl)));

endmodule

// File: tb/tb_xfer_priv_check.sv
module tb_xfer_priv_check;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic       req_nt = 1'b0;
  logic [1:0] req_cpl = '0;
  logic [1:0] req_rpl = '0;
  logic [2:0] req_kind = '0;
  logic [1:0] req_dpl = '0;
  logic [1:0] req_table = '0;
  logic [2:0] req_dst_kind = '0;
  logic [1:0] req_dst_dpl = '0;
  logic       rsp_valid;
  logic [1:0] rsp_result;
  logic       rsp_fault;
  logic [7:0] rsp_vector;
  logic [1:0] rsp_cpl;
  logic       rsp_pop_sp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xfer_priv_check dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_nt(req_nt),
    .req_cpl(req_cpl), .req_rpl(req_rpl), .req_kind(req_kind), .req_dpl(req_dpl),
    .req_table(req_table), .req_dst_kind(req_dst_kind), .req_dst_dpl(req_dst_dpl),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_fault(rsp_fault),
    .rsp_vector(rsp_vector), .rsp_cpl(rsp_cpl), .rsp_pop_sp(rsp_pop_sp)
  );

  // Reference outcome, computed from the requirement text with integers.
  task automatic model(input int o, input int n, input int k, input int t, input int c,
                       input int r, input int d, input int dk, input int dd,
                       output int f, output int res, output int nc, output int pop,
                       output string tag);
    bit seg_tab = (t == 0) || (t == 1);
    bit intr_op = (o >= 4) && (o <= 6);
    f = 1; res = 0; nc = c; pop = 0; tag = "R3";
    if (k == 0 || k == 1) begin
      if (seg_tab && o <= 1) begin
        tag = "R4";
        if (r <= c && ((k == 1) ? (d <= c) : (d == c))) f = 0;
      end else if (seg_tab && (o == 2 || (o == 3 && n == 0))) begin
        tag = "R5";
        if (d >= c && r >= c) begin
          f = 0; nc = r;
          if (r != c) begin res = 2; pop = 1; end
        end
      end
    end else if ((k == 2 && o == 1 && seg_tab) || ((k == 3 || k == 4) && intr_op && t == 2)) begin
      tag = "R7";
      if (d >= c && dk <= 1 && dd <= c) begin f = 0; res = 1; nc = dd; end
    end else if (k == 5 && ((o <= 1 && seg_tab) || (intr_op && t == 2))) begin
      tag = "R8";
      if (d >= c && dk == 6) begin f = 0; res = 3; end
    end else if (k == 6 && t == 0 && o <= 1) begin
      tag = "R6";
      if (d >= c) begin f = 0; res = 3; end
    end else if (k == 6 && t == 0 && o == 3 && n == 1) begin
      tag = "R9";
      f = 0; res = 3;
    end
    if (f == 1) nc = c;
  endtask

  task automatic run_one(input int o, input int n, input int k, input int t, input int c,
                         input int r, input int d, input int dk, input int dd);
    int ef, er, ec, ep;
    string tag;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = 3'(o); req_nt = n[0]; req_kind = 3'(k); req_table = 2'(t);
    req_cpl = 2'(c); req_rpl = 2'(r); req_dpl = 2'(d);
    req_dst_kind = 3'(dk); req_dst_dpl = 2'(dd);
    model(o, n, k, t, c, r, d, dk, dd, ef, er, ec, ep, tag);
    @(posedge clk);
    #1;
    checks++;
    // R1 valid, R2 encodings, R10 vector shape
    if (rsp_valid !== 1'b1 || rsp_fault !== ef[0] || rsp_result !== 2'(er) ||
        rsp_cpl !== 2'(ec) || rsp_pop_sp !== ep[0] ||
        rsp_vector !== (ef ? 8'd13 : 8'd0)) begin
      errors++;
      $display("FAIL %s/R10 op=%0d nt=%0d kind=%0d tab=%0d cpl=%0d rpl=%0d dpl=%0d dk=%0d dd=%0d actual v=%0b f=%0b res=%0d cpl=%0d pop=%0b vec=%0d expected v=1 f=%0d res=%0d cpl=%0d pop=%0d vec=%0d",
               tag, o, n, k, t, c, r, d, dk, dd, rsp_valid, rsp_fault, rsp_result, rsp_cpl,
               rsp_pop_sp, rsp_vector, ef, er, ec, ep, ef ? 13 : 0);
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s idle actual rsp_valid=%0b expected 0", tag, rsp_valid);
    end
  endtask

  initial begin
    int dks[4];
    int dds[3];
    dks = '{0, 1, 6, 7};
    dds = '{0, 1, 3};
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset actual rsp_valid=%0b expected 0", rsp_valid);
    end
    @(negedge clk);
    rst = 1'b0;
    check_idle("R1");

    // Directed corners first
    run_one(0, 0, 2, 0, 0, 0, 3, 0, 0);   // R3 JMP through call gate
    run_one(2, 0, 6, 0, 0, 0, 3, 0, 0);   // R3 RET to TSS
    run_one(1, 0, 1, 1, 2, 2, 0, 0, 0);   // R4 conforming, more privileged DPL
    run_one(2, 0, 0, 0, 1, 3, 3, 0, 0);   // R5 return outward with pop
    run_one(4, 0, 4, 2, 3, 0, 3, 0, 0);   // R7 interrupt gate to ring 0
    run_one(3, 1, 6, 0, 2, 0, 0, 0, 0);   // R9 nested IRET
    check_idle("R1");

    // Sweep: plain descriptors over every privilege triple
    for (int o = 0; o < 8; o++)
      for (int n = 0; n <= ((o == 3) ? 1 : 0); n++)
        for (int ki = 0; ki < 4; ki++)
          for (int t = 0; t < 4; t++)
            for (int c = 0; c < 4; c++)
              for (int r = 0; r < 4; r++)
                for (int d = 0; d < 4; d++)
                  run_one(o, n, (ki < 2) ? ki : ki + 4, t, c, r, d, 0, 0);

    // Sweep: gates with their destinations
    for (int o = 0; o < 8; o++)
      for (int n = 0; n <= ((o == 3) ? 1 : 0); n++)
        for (int k = 2; k <= 5; k++)
          for (int t = 0; t < 4; t++)
            for (int c = 0; c < 4; c++)
              for (int d = 0; d < 4; d++)
                for (int di = 0; di < 4; di++)
                  for (int ddi = 0; ddi < 3; ddi++)
                    run_one(o, n, k, t, c, 0, d, dks[di], dds[ddi]);

    check_idle("R1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule